// File: doc/BRIEF.md
# Capture/Compare PWM Timer Unit

This block is a 16-bit timer with a programmable prescaler, four compare channels that drive PWM-style outputs, and two input capture channels. The timer runs in one of three modes: a basic up/down count whose direction may be flipped while running, an edge-aligned PWM mode that always counts down, and a centre-aligned PWM mode that climbs to the reload value and falls back to zero. At every overflow the timer loads a programmed reload value.

Each compare channel raises a flag when the timer equals its compare value. In the PWM modes it drives its output active while the timer is below that value, with a per-channel polarity inversion. In edge-aligned mode the four outputs can be grouped into two pairs that take turns on successive counter periods. Each capture channel samples its input pin on the block clock. It can use a four-sample glitch filter, and it can skip a programmed number of qualifying edges before it copies the timer. All seven event flags are sticky and share one request line.

Configuration arrives on plain input ports held by the surrounding logic. The input pins must already be synchronous to the block clock.

Top module: `cap_cmp_timer`

## Requirements
- R1: After reset the timer reads 0, all seven flags and `irq` are 0, both capture registers read 0, and with all polarity bits at 0 every output is 0.
- R2: The timer advances once every `presc_div`+1 clocks (1 to 1024) while `run` is high. While `run` is low the timer holds its value.
- R3: With `mode`=0 (basic), the timer counts up when `dir_down`=0 and down when `dir_down`=1, and the direction may change at any time. Counting up past 16'hFFFF, or down past 0, loads `reload` and sets flag bit 0 on that same clock edge.
- R4: With `mode`=1 (edge-aligned PWM), the timer counts down whatever `dir_down` says, and loads `reload` after reaching 0.
- R5: With `mode`=2 (centre-aligned PWM, `reload` of at least 1), the timer counts up from 0 to `reload` and then down to 0. The step after 0 goes to 1 and sets flag bit 0, which gives a period of 2×`reload` ticks.
- R6: While `run` is high, a timer value equal to channel i's compare value (i=0..3 for A..D, at `cmp_val[16i+15:16i]`) sets flag bit 3+i one clock later.
- R7: In modes 1 and 2, channel i's raw output is active while the timer is below its compare value. `pwm_out[i]` is the raw output XOR `cmp_inv[i]`. In mode 0 the raw output is inactive, so `pwm_out` equals `cmp_inv`.
- R8: In mode 1 with `pair_en`=1, a period phase toggles at every overflow and starts at 0 after reset. Phase 0 enables channels A and B, phase 1 enables C and D, and a disabled channel's raw output is inactive. In mode 2, `pair_en` has no effect.
- R9: Capture channel j (pin `cap_pin[j]`) accepts a rising edge when `cap_fall[j]`=0 and a falling edge when it is 1, and ignores the other edge. On capture it copies the timer value of the cycle before the capture edge into `cap_val[16j+15:16j]` and sets flag bit 1+j. Unfiltered, this happens on the second clock edge after the pin changes.
- R10: With `cap_filt[j]`=1, a new pin level is accepted only after four consecutive equal samples, so capture happens on the fifth clock edge. A pulse shorter than four clocks is ignored.
- R11: With `cap_evt[4j+3:4j]`=N, channel j captures only on every (N+1)-th qualifying edge. After a capture the count starts over.
- R12: `irq` is high whenever any flag is set. A one-cycle pulse on `flag_clr[k]` clears flag k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| run | input | 1 | Timer and prescaler enable |
| presc_div | input | 10 | Prescale divisor minus one |
| reload | input | 16 | Value loaded at overflow |
| dir_down | input | 1 | Basic-mode direction, 1 = down |
| mode | input | 2 | 0 basic, 1 edge-aligned PWM, 2 centre-aligned PWM, 3 as basic |
| pair_en | input | 1 | Alternating A/B and C/D pairs in edge-aligned mode |
| cmp_val | input | 64 | Four compare values, channel i at bits 16i+15:16i |
| cmp_inv | input | 4 | Output polarity inversion per channel |
| cap_pin | input | 2 | Capture input pins |
| cap_fall | input | 2 | Capture edge select, 1 = falling |
| cap_filt | input | 2 | Four-sample filter enable |
| cap_evt | input | 8 | Edges skipped before capture, channel j at bits 4j+3:4j |
| flag_clr | input | 7 | Flag clear pulses |
| tmr | output | 16 | Timer value |
| pwm_out | output | 4 | Compare channel outputs A..D |
| cap_val | output | 32 | Capture registers, channel j at bits 16j+15:16j |
| flags | output | 7 | Bit 0 overflow, bits 1-2 capture, bits 3-6 compare A..D |
| irq | output | 1 | Shared interrupt request |

## Verification
Different results arrive at different times. The timer and the overflow flag change on the clock edge of the prescaler tick. `pwm_out` follows the timer in the same cycle. A compare flag appears one edge after the matching timer value. An unfiltered capture lands two edges after the pin changes, and a filtered capture lands five edges after. The bench drives every input on the falling edge and samples there too, counting rising edges between stimulus and check. It checks the cycle before a due result as well as the cycle it is due, which pins down each latency. Timer sequences are compared against a stepwise model of the mode rules, run for the number of ticks the prescaler allows.

// File: rtl/ccpt_pkg.sv
package ccpt_pkg;
  typedef enum logic [1:0] {
    MODE_BASIC = 2'd0,
    MODE_ASYM  = 2'd1,
    MODE_SYM   = 2'd2,
    MODE_RSVD  = 2'd3
  } mode_e;
endpackage

// File: rtl/ccpt_prescale.sv
module ccpt_prescale #(
  parameter int PW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [PW-1:0] div,
  output logic          tick
);
  logic [PW-1:0] pc_q, pc_d;

  always_comb begin
    tick = 1'b0;
    pc_d = '0;
    if (run) begin
      if (pc_q >= div) begin
        tick = 1'b1;
      end else begin
        pc_d = pc_q + PW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end
endmodule

// File: rtl/ccpt_counter.sv
module ccpt_counter
  import ccpt_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  mode_e         mode,
  input  logic          dir_down,
  input  logic [TW-1:0] reload,
  output logic [TW-1:0] tmr,
  output logic          ovf,
  output logic          phase
);
  localparam logic [TW-1:0] TOP = '1;
  localparam logic [TW-1:0] ONE = TW'(1);

  logic [TW-1:0] tmr_d;
  logic          sdn_q, sdn_d, ph_d;

  always_comb begin
    tmr_d = tmr;
    sdn_d = (mode == MODE_SYM) ? sdn_q : 1'b0;
    ovf   = 1'b0;
    if (tick) begin
      unique case (mode)
        MODE_ASYM: begin
          if (tmr == '0) begin tmr_d = reload; ovf = 1'b1; end
          else           tmr_d = tmr - ONE;
        end
        MODE_SYM: begin
          if (!sdn_q) begin
            if (tmr >= reload) begin
              sdn_d = 1'b1;
              tmr_d = (tmr == '0) ? '0 : tmr - ONE;
            end else begin
              tmr_d = tmr + ONE;
            end
          end else if (tmr == '0) begin
            sdn_d = 1'b0;
            ovf   = 1'b1;
            tmr_d = (reload == '0) ? '0 : ONE;
          end else begin
            tmr_d = tmr - ONE;
          end
        end
        default: begin
          if (dir_down) begin
            if (tmr == '0) begin tmr_d = reload; ovf = 1'b1; end
            else           tmr_d = tmr - ONE;
          end else begin
            if (tmr == TOP) begin tmr_d = reload; ovf = 1'b1; end
            else            tmr_d = tmr + ONE;
          end
        end
      endcase
    end
    if (mode != MODE_ASYM) ph_d = 1'b0;
    else if (ovf)          ph_d = ~phase;
    else                   ph_d = phase;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr   <= '0;
      sdn_q <= 1'b0;
      phase <= 1'b0;
    end else begin
      tmr   <= tmr_d;
      sdn_q <= sdn_d;
      phase <= ph_d;
    end
  end
endmodule

// File: rtl/ccpt_cmp_ch.sv
module ccpt_cmp_ch #(
  parameter int TW = 16
) (
  input  logic [TW-1:0] tmr,
  input  logic [TW-1:0] cmp,
  input  logic          inv,
  input  logic          pwm_mode,
  input  logic          gate_en,
  output logic          match,
  output logic          out
);
  logic raw;

  always_comb begin
    match = (tmr == cmp);
    raw   = pwm_mode && gate_en && (tmr < cmp);
    out   = raw ^ inv;
  end
endmodule

// File: rtl/ccpt_cap_ch.sv
module ccpt_cap_ch #(
  parameter int TW = 16,
  parameter int EW = 4,
  parameter int FD = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pin,
  input  logic          fall_sel,
  input  logic          filt_en,
  input  logic [EW-1:0] evt_num,
  input  logic [TW-1:0] tmr,
  output logic [TW-1:0] cap_val,
  output logic          hit
);
  logic [FD-1:0] smp_q, smp_d;
  logic          lvl_q, cand, edge_ok;
  logic [EW-1:0] evc_q, evc_d;
  logic [TW-1:0] cap_d;

  always_comb begin
    smp_d = {smp_q[FD-2:0], pin};
    if (!filt_en)       cand = smp_q[0];
    else if (&smp_q)    cand = 1'b1;
    else if (~|smp_q)   cand = 1'b0;
    else                cand = lvl_q;
    edge_ok = (cand != lvl_q) && (cand ^ fall_sel);
    hit     = edge_ok && (evc_q >= evt_num);
    evc_d   = evc_q;
    if (edge_ok) evc_d = hit ? '0 : evc_q + EW'(1);
    cap_d   = hit ? tmr : cap_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q   <= '0;
      lvl_q   <= 1'b0;
      evc_q   <= '0;
      cap_val <= '0;
    end else begin
      smp_q   <= smp_d;
      lvl_q   <= cand;
      evc_q   <= evc_d;
      cap_val <= cap_d;
    end
  end
endmodule

// File: rtl/cap_cmp_timer.sv
module cap_cmp_timer
  import ccpt_pkg::*;
#(
  parameter int TW   = 16,
  parameter int PW   = 10,
  parameter int NCMP = 4,
  parameter int NCAP = 2,
  parameter int EW   = 4,
  localparam int NF  = 1 + NCAP + NCMP
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic [PW-1:0]      presc_div,
  input  logic [TW-1:0]      reload,
  input  logic               dir_down,
  input  logic [1:0]         mode,
  input  logic               pair_en,
  input  logic [NCMP*TW-1:0] cmp_val,
  input  logic [NCMP-1:0]    cmp_inv,
  input  logic [NCAP-1:0]    cap_pin,
  input  logic [NCAP-1:0]    cap_fall,
  input  logic [NCAP-1:0]    cap_filt,
  input  logic [NCAP*EW-1:0] cap_evt,
  input  logic [NF-1:0]      flag_clr,
  output logic [TW-1:0]      tmr,
  output logic [NCMP-1:0]    pwm_out,
  output logic [NCAP*TW-1:0] cap_val,
  output logic [NF-1:0]      flags,
  output logic               irq
);
  logic           rs1_q, rst_i;
  logic           tick, ovf, phase;
  mode_e          mode_m;
  logic           pwm_mode, pair_mode;
  logic [NCMP-1:0] cmp_match;
  logic [NCAP-1:0] cap_hit;
  logic [NF-1:0]   set_vec, flags_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rst_i <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rst_i <= rs1_q;
    end
  end

  assign mode_m    = mode_e'(mode);
  assign pwm_mode  = (mode_m == MODE_ASYM) || (mode_m == MODE_SYM);
  assign pair_mode = pair_en && (mode_m == MODE_ASYM);

  ccpt_prescale #(.PW(PW)) u_presc (
    .clk(clk), .rst_n(rst_i), .run(run), .div(presc_div), .tick(tick)
  );

  ccpt_counter #(.TW(TW)) u_cnt (
    .clk(clk), .rst_n(rst_i), .tick(tick), .mode(mode_m),
    .dir_down(dir_down), .reload(reload), .tmr(tmr), .ovf(ovf), .phase(phase)
  );

  for (genvar i = 0; i < NCMP; i++) begin : g_cmp
    localparam bit PSEL = ((i / 2) % 2) == 1;
    logic gate;
    assign gate = !pair_mode || (phase == PSEL);
    ccpt_cmp_ch #(.TW(TW)) u_ch (
      .tmr(tmr), .cmp(cmp_val[i*TW +: TW]), .inv(cmp_inv[i]),
      .pwm_mode(pwm_mode), .gate_en(gate),
      .match(cmp_match[i]), .out(pwm_out[i])
    );
  end

  for (genvar j = 0; j < NCAP; j++) begin : g_cap
    ccpt_cap_ch #(.TW(TW), .EW(EW)) u_cap (
      .clk(clk), .rst_n(rst_i), .pin(cap_pin[j]), .fall_sel(cap_fall[j]),
      .filt_en(cap_filt[j]), .evt_num(cap_evt[j*EW +: EW]), .tmr(tmr),
      .cap_val(cap_val[j*TW +: TW]), .hit(cap_hit[j])
    );
  end

  always_comb begin
    set_vec = {cmp_match & {NCMP{run}}, cap_hit, ovf};
    flags_d = (flags & ~flag_clr) | set_vec;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) flags <= '0;
    else        flags <= flags_d;
  end

  assign irq = |flags;
endmodule

// File: rtl/ccpt_chk.sv
module ccpt_chk #(
  parameter int TW   = 16,
  parameter int PW   = 10,
  parameter int NCMP = 4,
  parameter int NCAP = 2,
  parameter int NF   = 1 + NCAP + NCMP
) (
  input logic               clk,
  input logic               rst_i,
  input logic               run,
  input logic [PW-1:0]      presc_div,
  input logic [1:0]         mode,
  input logic [TW-1:0]      reload,
  input logic [NCMP-1:0]    cmp_inv,
  input logic [TW-1:0]      tmr,
  input logic [NCMP-1:0]    pwm_out,
  input logic [NF-1:0]      flags,
  input logic [NCAP*TW-1:0] cap_val
);
  p_hold_stopped_r2: assert property (@(posedge clk) disable iff (!rst_i)
    !run |=> $stable(tmr));

  p_ovf_reload_r3: assert property (@(posedge clk) disable iff (!rst_i)
    ($rose(flags[0]) && mode != 2'd2 && $stable(reload) && $stable(mode)) |-> tmr == reload);

  p_asym_down_r4: assert property (@(posedge clk) disable iff (!rst_i)
    (run && mode == 2'd1 && presc_div == '0 && tmr != '0) |=> tmr == $past(tmr) - TW'(1));

  p_basic_idle_r7: assert property (@(posedge clk) disable iff (!rst_i)
    mode == 2'd0 |-> pwm_out == cmp_inv);

  p_cap_copy_r9: assert property (@(posedge clk) disable iff (!rst_i)
    $rose(flags[1]) |-> cap_val[TW-1:0] == $past(tmr));
endmodule

bind cap_cmp_timer ccpt_chk #(.TW(TW), .PW(PW), .NCMP(NCMP), .NCAP(NCAP)) u_chk (
  .clk(clk), .rst_i(rst_i), .run(run), .presc_div(presc_div), .mode(mode),
  .reload(reload), .cmp_inv(cmp_inv), .tmr(tmr), .pwm_out(pwm_out),
  .flags(flags), .cap_val(cap_val)
);

// File: tb/cap_cmp_timer_tb.sv
module cap_cmp_timer_tb;
  logic        clk, rst_n, run, dir_down, pair_en;
  logic [9:0]  presc_div;
  logic [15:0] reload, tmr;
  logic [1:0]  mode, cap_pin, cap_fall, cap_filt;
  logic [63:0] cmp_val;
  logic [3:0]  cmp_inv, pwm_out;
  logic [7:0]  cap_evt;
  logic [6:0]  flag_clr, flags;
  logic [31:0] cap_val;
  logic        irq;
  int n_chk = 0;
  int n_bad = 0;

  cap_cmp_timer u_dut (
    .clk(clk), .rst_n(rst_n), .run(run), .presc_div(presc_div), .reload(reload),
    .dir_down(dir_down), .mode(mode), .pair_en(pair_en), .cmp_val(cmp_val),
    .cmp_inv(cmp_inv), .cap_pin(cap_pin), .cap_fall(cap_fall), .cap_filt(cap_filt),
    .cap_evt(cap_evt), .flag_clr(flag_clr), .tmr(tmr), .pwm_out(pwm_out),
    .cap_val(cap_val), .flags(flags), .irq(irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // div, reload, mode, dir_down, clock edges with run high
  localparam logic [44:0] VT [7] = '{
    {10'd0,    16'd5, 2'd0, 1'b0, 16'd20},
    {10'd0,    16'd5, 2'd0, 1'b1, 16'd20},
    {10'd2,    16'd7, 2'd1, 1'b0, 16'd30},
    {10'd0,    16'd4, 2'd2, 1'b0, 16'd13},
    {10'd3,    16'd3, 2'd2, 1'b1, 16'd50},
    {10'd1023, 16'd9, 2'd0, 1'b0, 16'd3000},
    {10'd0,    16'd0, 2'd0, 1'b1, 16'd5}
  };

  function automatic logic [15:0] model(logic [1:0] md, logic dn, logic [15:0] rel, int t);
    logic [15:0] v = '0;
    logic sd = 1'b0;
    for (int i = 0; i < t; i++) begin
      if (md == 2'd1 || (md != 2'd2 && dn)) v = (v == 16'd0) ? rel : v - 16'd1;
      else if (md == 2'd2) begin
        if (!sd) begin
          if (v >= rel) begin sd = 1'b1; v = v - 16'd1; end
          else v = v + 16'd1;
        end else if (v == 16'd0) begin sd = 1'b0; v = 16'd1; end
        else v = v - 16'd1;
      end else v = (v == 16'hFFFF) ? rel : v + 16'd1;
    end
    return v;
  endfunction

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; run = 1'b0; presc_div = '0; reload = '0; dir_down = 1'b0;
    mode = 2'd0; pair_en = 1'b0; cmp_val = {4{16'd1000}}; cmp_inv = '0;
    cap_pin = '0; cap_fall = '0; cap_filt = '0; cap_evt = '0; flag_clr = '0;
    cyc(2);
    rst_n = 1'b1;
    cyc(3);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R1 watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    // timer sequence vectors: R2 prescale, R3 basic, R4 asym, R5 sym
    for (int k = 0; k < 7; k++) begin
      logic [44:0] v;
      string tag;
      v = VT[k];
      do_reset();
      presc_div = v[44:35]; reload = v[34:19]; mode = v[18:17]; dir_down = v[16];
      run = 1'b1;
      cyc(int'(v[15:0]));
      run = 1'b0;
      if (v[44:35] != 10'd0) tag = "R2";
      else if (v[18:17] == 2'd1) tag = "R4";
      else if (v[18:17] == 2'd2) tag = "R5";
      else tag = "R3";
      chk(tag, 32'(tmr), 32'(model(v[18:17], v[16], v[34:19],
                                 int'(v[15:0]) / (int'(v[44:35]) + 1))));
    end

    // R1 reset state
    do_reset();
    chk("R1 tmr", 32'(tmr), 0);
    chk("R1 flags", 32'(flags), 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 cap", cap_val, 0);
    chk("R1 out", 32'(pwm_out), 0);

    // R3 reversal mid-run and down overflow
    do_reset();
    reload = 16'd100; run = 1'b1;
    cyc(10); chk("R3 up", 32'(tmr), 10);
    dir_down = 1'b1;
    cyc(3);  chk("R3 reversed", 32'(tmr), 7);
    cyc(7);  chk("R3 at zero", 32'(flags[0]), 0);
    cyc(1);  chk("R3 down reload", 32'(tmr), 100);
    chk("R3 ovf flag", 32'(flags[0]), 1);

    // R3 up overflow, R12 clear
    do_reset();
    reload = 16'hFFFE; dir_down = 1'b1; run = 1'b1;
    cyc(1); run = 1'b0;
    chk("R3 reload", 32'(tmr), 32'hFFFE);
    chk("R12 irq set", 32'(irq), 1);
    flag_clr = 7'h01; cyc(1); flag_clr = '0;
    chk("R12 cleared", 32'(flags), 0);
    chk("R12 irq low", 32'(irq), 0);
    dir_down = 1'b0; run = 1'b1;
    cyc(1); chk("R3 top", 32'(tmr), 32'hFFFF);
    chk("R3 no ovf yet", 32'(flags[0]), 0);
    cyc(1); chk("R3 up wrap", 32'(tmr), 32'hFFFE);
    chk("R3 up ovf", 32'(flags[0]), 1);

    // R6 compare flag one cycle after match
    do_reset();
    reload = 16'd100; cmp_val[31:16] = 16'd6; run = 1'b1;
    cyc(6); chk("R6 match cycle", 32'(flags), 0);
    cyc(1); chk("R6 flag B", 32'(flags), 32'h10);
    chk("R12 irq", 32'(irq), 1);

    // R7 basic mode: outputs equal polarity
    do_reset();
    cmp_inv = 4'b0101; cmp_val[15:0] = 16'd50; run = 1'b1;
    cyc(5); chk("R7 basic idle", 32'(pwm_out), 32'h5);

    // R7 edge-aligned PWM with inversion on B, D compare 0
    do_reset();
    mode = 2'd1; reload = 16'd9; cmp_inv = 4'b0010;
    cmp_val = {16'd0, 16'd0, 16'd4, 16'd4}; run = 1'b1;
    for (int i = 0; i < 25; i++) begin
      logic lo;
      cyc(1);
      lo = (tmr < 16'd4);
      chk("R7 asym pwm", 32'(pwm_out), 32'({1'b0, 1'b0, ~lo, lo}));
    end

    // R8 alternating pairs
    do_reset();
    mode = 2'd1; pair_en = 1'b1; reload = 16'd3; cmp_val = {4{16'd4}}; run = 1'b1;
    cyc(1); chk("R8 phase1 CD", 32'(pwm_out), 32'hC);
    cyc(4); chk("R8 phase0 AB", 32'(pwm_out), 32'h3);
    cyc(4); chk("R8 phase1 again", 32'(pwm_out), 32'hC);
    mode = 2'd2;
    cyc(2); chk("R8 sym ignores pairs", 32'(pwm_out), 32'hF);

    // R9 capture, rising on ch0, falling on ch1
    do_reset();
    reload = 16'd1000; cap_fall = 2'b10; run = 1'b1;
    cyc(37); run = 1'b0;
    cap_pin[0] = 1'b1;
    cyc(1); chk("R9 not yet", 32'(flags[1]), 0);
    cyc(1); chk("R9 flag", 32'(flags[1]), 1);
    chk("R9 value", 32'(cap_val[15:0]), 37);
    cap_pin[1] = 1'b1;
    cyc(3); chk("R9 rise ignored", 32'(flags[2]), 0);
    chk("R9 ch1 untouched", 32'(cap_val[31:16]), 0);
    run = 1'b1; cyc(3); run = 1'b0;
    cap_pin[1] = 1'b0;
    cyc(2); chk("R9 fall flag", 32'(flags[2]), 1);
    chk("R9 fall value", 32'(cap_val[31:16]), 40);

    // R10 filter
    do_reset();
    cap_filt = 2'b01; reload = 16'd1000; run = 1'b1; cyc(9); run = 1'b0;
    cap_pin[0] = 1'b1; cyc(3); cap_pin[0] = 1'b0;
    cyc(8); chk("R10 glitch ignored", 32'(flags[1]), 0);
    cap_pin[0] = 1'b1;
    cyc(4); chk("R10 not yet", 32'(flags[1]), 0);
    cyc(1); chk("R10 accepted", 32'(flags[1]), 1);
    chk("R10 value", 32'(cap_val[15:0]), 9);

    // R11 event count
    do_reset();
    cap_evt = 8'h02; reload = 16'd1000; run = 1'b1; cyc(5); run = 1'b0;
    for (int p = 0; p < 2; p++) begin
      cap_pin[0] = 1'b1; cyc(2); cap_pin[0] = 1'b0; cyc(2);
    end
    chk("R11 two edges", 32'(flags[1]), 0);
    cap_pin[0] = 1'b1; cyc(2);
    chk("R11 third edge", 32'(flags[1]), 1);
    chk("R11 value", 32'(cap_val[15:0]), 5);
    cap_pin[0] = 1'b0; flag_clr = 7'h02; cyc(1); flag_clr = '0;
    run = 1'b1; cyc(4); run = 1'b0; cyc(1);
    for (int p = 0; p < 2; p++) begin
      cap_pin[0] = 1'b1; cyc(2); cap_pin[0] = 1'b0; cyc(2);
    end
    chk("R11 restarted", 32'(flags[1]), 0);
    chk("R11 kept value", 32'(cap_val[15:0]), 5);
    cap_pin[0] = 1'b1; cyc(2);
    chk("R11 next capture", 32'(cap_val[15:0]), 9);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule